// File: doc/BRIEF.md
# Parked Message Buffer

This block is a storage endpoint that sits on one port of an on-chip network and holds the payload of a transfer whose receiver does not yet exist. A channel manager engages it with a request that gives it a role. As a sink, it takes one message from its input stream and writes every word into a single-port RAM. Later, as a source, it replays that message on its output stream in the order the words were written. It stays reserved from the first request until the manager releases it after the replay.

The buffer serves one parked transfer at a time. While it holds or replays a message, any further request is refused, even if RAM capacity remains. The manager sees a busy flag, a flag that says undelivered data is present, the number of stored words, and an overflow flag. The overflow flag is raised when a message is longer than the RAM. Capacity and data width are parameters.

Top module: `parked_msg_buffer`

## Requirements
- R1: After reset, busy, has_data, overflow, in_ready, out_valid, cmd_grant and cmd_refuse are 0 and stored_len is 0.
- R2: A request with cmd_send=0 while the block is idle is granted. In the cycle after the request, cmd_grant pulses high for one cycle, busy is 1 and in_ready is 1.
- R3: While filling, each input beat with in_valid and in_ready is written in arrival order and stored_len counts the written words. The beat with in_last=1 ends the fill: from the next cycle in_ready is 0, has_data is 1 and busy stays 1.
- R4: Beats that arrive after DEPTH words are stored are still taken from the input stream but are discarded. In that case overflow becomes 1 and stored_len stays at DEPTH.
- R5: A request with cmd_send=1 is granted only while the block holds an undelivered message. The output stream then delivers exactly stored_len words in write order, with out_last=1 on the final word only.
- R6: While out_valid=1 and out_ready=0, out_valid and out_data stay unchanged into the next cycle.
- R7: A request that does not match the current state produces a one-cycle cmd_refuse pulse and leaves busy, has_data and stored_len unchanged. Such requests are a fill request while the block is not idle (including when RAM space remains) and a send request while no undelivered message is held.
- R8: After the final word is delivered, has_data is 0 and busy stays 1 until cmd_release is pulsed. After the release, busy, stored_len and overflow return to 0.
- R9: cmd_release has no effect before the final word is delivered. busy and has_data stay 1 and the stored message is still delivered in full.
- R10: The RAM is never read and written in the same cycle. In particular, in_ready and out_valid are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Role request from the channel manager, one cycle |
| cmd_send | input | 1 | Role with cmd_req: 0 = take and store, 1 = replay stored |
| cmd_release | input | 1 | Return to idle after delivery, one cycle |
| cmd_grant | output | 1 | Request accepted, one-cycle pulse |
| cmd_refuse | output | 1 | Request refused, one-cycle pulse |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Input stream ready (high only while filling) |
| in_data | input | DATA_W | Input stream word |
| in_last | input | 1 | Final word of the input message |
| out_valid | output | 1 | Output stream word valid |
| out_ready | input | 1 | Output stream ready |
| out_data | output | DATA_W | Output stream word |
| out_last | output | 1 | Final word of the replayed message |
| busy | output | 1 | Buffer engaged in a parked transfer |
| has_data | output | 1 | Undelivered message present |
| stored_len | output | $clog2(DEPTH+1) | Words stored for the current message |
| overflow | output | 1 | Message exceeded capacity; extra words dropped |

## Verification
The bench goes after four cases. The first is a one-word message, where a design off by one on the end-of-replay compare either never raises out_last or repeats a word. The second is a message that exactly fills the RAM and one that exceeds it, where a wrong capacity check would wrap the address and overwrite early words, or would stall the input stream instead of dropping the extra beats. The third is output backpressure on every other cycle, where a design that launches a RAM read while the consumer stalls would change out_data under a held valid. The last covers requests and releases at the wrong time: a fill request while a message is parked and a release before delivery. A design that got these wrong would corrupt or lose the parked message.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

  typedef enum logic [2:0] {
    PMB_IDLE  = 3'd0,
    PMB_FILL  = 3'd1,
    PMB_HOLD  = 3'd2,
    PMB_DRAIN = 3'd3,
    PMB_SPENT = 3'd4
  } pmb_state_e;

  // A request is honoured only when its role fits the current phase.
  function automatic logic role_fits(pmb_state_e st, logic want_send);
    return (st == PMB_IDLE && !want_send) || (st == PMB_HOLD && want_send);
  endfunction

endpackage

// File: rtl/pmb_ram.sv
module pmb_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // One port: a cycle either writes or reads, never both.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/pmb_ctrl.sv
module pmb_ctrl
  import pmb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_req,
  input  logic          cmd_send,
  input  logic          cmd_release,
  output logic          cmd_grant,
  output logic          cmd_refuse,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic          busy,
  output logic          has_data,
  output logic [CW-1:0] stored_len,
  output logic          overflow
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  function automatic logic room_left(logic [CW-1:0] written);
    return written < CAP;
  endfunction

  function automatic logic words_pending(logic [CW-1:0] issued, logic [CW-1:0] len);
    return issued != len;
  endfunction

  pmb_state_e    st;
  logic [CW-1:0] wr_cnt;
  logic [CW-1:0] rd_cnt;
  logic          out_valid_q;
  logic          ovf_q;
  logic          grant_q;
  logic          refuse_q;

  // Named internal events
  logic in_fire, wr_hit, drop_hit, rd_issue, out_fire;
  logic req_ok, req_bad, release_ok;

  assign in_ready   = (st == PMB_FILL);
  assign in_fire    = in_valid && in_ready;
  assign wr_hit     = in_fire && room_left(wr_cnt);
  assign drop_hit   = in_fire && !room_left(wr_cnt);
  assign out_fire   = out_valid_q && out_ready;
  assign rd_issue   = (st == PMB_DRAIN) && words_pending(rd_cnt, wr_cnt)
                      && (!out_valid_q || out_ready);
  assign req_ok     = cmd_req && role_fits(st, cmd_send);
  assign req_bad    = cmd_req && !req_ok;
  assign release_ok = cmd_release && (st == PMB_SPENT);

  assign ram_en     = wr_hit || rd_issue;
  assign ram_we     = wr_hit;
  assign ram_addr   = wr_hit ? wr_cnt[AW-1:0] : rd_cnt[AW-1:0];

  assign out_valid  = out_valid_q;
  assign out_last   = out_valid_q && !words_pending(rd_cnt, wr_cnt);
  assign busy       = (st != PMB_IDLE);
  assign has_data   = (st == PMB_HOLD) || (st == PMB_DRAIN);
  assign stored_len = wr_cnt;
  assign overflow   = ovf_q;
  assign cmd_grant  = grant_q;
  assign cmd_refuse = refuse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= PMB_IDLE;
      wr_cnt      <= '0;
      rd_cnt      <= '0;
      out_valid_q <= 1'b0;
      ovf_q       <= 1'b0;
      grant_q     <= 1'b0;
      refuse_q    <= 1'b0;
    end else begin
      grant_q  <= req_ok;
      refuse_q <= req_bad;
      if (wr_hit)   wr_cnt <= wr_cnt + 1'b1;
      if (drop_hit) ovf_q  <= 1'b1;
      if (rd_issue) rd_cnt <= rd_cnt + 1'b1;
      if (rd_issue)       out_valid_q <= 1'b1;
      else if (out_ready) out_valid_q <= 1'b0;
      unique case (st)
        PMB_IDLE: if (req_ok) begin
          st     <= PMB_FILL;
          wr_cnt <= '0;
          rd_cnt <= '0;
          ovf_q  <= 1'b0;
        end
        PMB_FILL:  if (in_fire && in_last) st <= PMB_HOLD;
        PMB_HOLD:  if (req_ok) begin
          st     <= PMB_DRAIN;
          rd_cnt <= '0;
        end
        PMB_DRAIN: if (out_fire && out_last) st <= PMB_SPENT;
        PMB_SPENT: if (release_ok) begin
          st     <= PMB_IDLE;
          wr_cnt <= '0;
          rd_cnt <= '0;
          ovf_q  <= 1'b0;
        end
        default: st <= PMB_IDLE;
      endcase
    end
  end

  // R2: idle fill request is granted and opens the input stream
  p_grant_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_req && !cmd_send) |=> (cmd_grant && in_ready));

  // R4: a beat past capacity raises overflow and leaves the count at capacity
  p_drop_keeps_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && stored_len == CAP) |=> (overflow && stored_len == CAP));

  // R5: the stored length cannot move while a message is parked or replaying
  p_len_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    has_data |=> $stable(stored_len));

  // R6: a stalled output word keeps its valid
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R7: a fill request while engaged is refused
  p_refuse_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_req && !cmd_send) |=> (cmd_refuse && !cmd_grant));

  // R9: a release while data is undelivered keeps the buffer engaged
  p_early_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_release && has_data) |=> busy);

  // R10: input and output sides of the single port never overlap
  p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

// File: rtl/parked_msg_buffer.sv
module parked_msg_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_req,
  input  logic              cmd_send,
  input  logic              cmd_release,
  output logic              cmd_grant,
  output logic              cmd_refuse,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              busy,
  output logic              has_data,
  output logic [CW-1:0]     stored_len,
  output logic              overflow
);

  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;

  pmb_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_req(cmd_req), .cmd_send(cmd_send), .cmd_release(cmd_release),
    .cmd_grant(cmd_grant), .cmd_refuse(cmd_refuse),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .busy(busy), .has_data(has_data), .stored_len(stored_len),
    .overflow(overflow)
  );

  pmb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(in_data), .rdata(out_data)
  );

  // R6: a stalled output word keeps its value
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

endmodule

// File: tb/tb_parked_msg_buffer.sv
`timescale 1ns/1ps
module tb_parked_msg_buffer;

  localparam int DW  = 16;
  localparam int DEP = 8;
  localparam int CW  = $clog2(DEP + 1);
  localparam int NCASE = 5;
  // [31:24] word count, [23:8] seed, [0] gappy handshakes
  localparam logic [31:0] CASES [NCASE] = '{
    32'h01_0100_00, 32'h03_2A05_01, 32'h08_00F0_00,
    32'h0B_7770_01, 32'h06_ABCD_01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_req = 0, cmd_send = 0, cmd_release = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic cmd_grant, cmd_refuse, in_ready, out_valid, out_last;
  logic busy, has_data, overflow;
  logic [DW-1:0] out_data;
  logic [CW-1:0] stored_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  parked_msg_buffer #(.DATA_W(DW), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_send(cmd_send),
    .cmd_release(cmd_release), .cmd_grant(cmd_grant), .cmd_refuse(cmd_refuse),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .busy(busy),
    .has_data(has_data), .stored_len(stored_len), .overflow(overflow)
  );

  function automatic logic [DW-1:0] word_at(logic [15:0] seed, int i);
    return DW'(seed + 16'(i * 37));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic request(logic send);
    cmd_req = 1'b1; cmd_send = send;
    tick();
    cmd_req = 1'b0; cmd_send = 1'b0;
  endtask

  task automatic release_pulse();
    cmd_release = 1'b1;
    tick();
    cmd_release = 1'b0;
  endtask

  task automatic fill(int n, logic [15:0] seed, bit gappy);
    for (int i = 0; i < n; i++) begin
      if (gappy && (i % 2 == 1)) begin
        in_valid = 1'b0;
        tick();
      end
      in_valid = 1'b1; in_data = word_at(seed, i); in_last = (i == n - 1);
      tick();
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain(int n, logic [15:0] seed, bit gappy);
    int got = 0;
    int guard = 0;
    bit flip = 0;
    logic r, sv;
    logic [DW-1:0] sd;
    while (got < n && guard < 500) begin
      r = gappy ? flip : 1'b1;
      flip = ~flip;
      out_ready = r;
      chk("R10 in_ready low while replaying", in_ready, 0);
      if (out_valid && r) begin
        chk("R5 replay word", out_data, word_at(seed, got));
        chk("R5 out_last position", out_last, (got == n - 1));
        got++;
      end
      sv = out_valid; sd = out_data;
      tick();
      guard++;
      if (sv && !r) begin
        chk("R6 valid held under stall", out_valid, 1);
        chk("R6 data held under stall", out_data, sd);
      end
    end
    out_ready = 1'b0;
    chk("R5 word count delivered", got, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 has_data", has_data, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 in_ready", in_ready, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 grant", cmd_grant, 0);
    chk("R1 refuse", cmd_refuse, 0);
    chk("R1 stored_len", stored_len, 0);

    // R7: a replay request with nothing parked is refused
    request(1'b1);
    chk("R7 refuse send when idle", cmd_refuse, 1);
    chk("R7 no grant when idle", cmd_grant, 0);
    chk("R7 still idle", busy, 0);

    for (int c = 0; c < NCASE; c++) begin
      int n = int'(CASES[c][31:24]);
      logic [15:0] seed = CASES[c][23:8];
      bit gappy = CASES[c][0];
      int kept = (n > DEP) ? DEP : n;

      request(1'b0);
      chk("R2 grant fill", cmd_grant, 1);
      chk("R2 busy", busy, 1);
      chk("R2 in_ready", in_ready, 1);
      tick();
      chk("R2 grant is one pulse", cmd_grant, 0);

      fill(n, seed, gappy);
      chk("R3 fill closed", in_ready, 0);
      chk("R3 has_data", has_data, 1);
      chk("R3 busy", busy, 1);
      chk("R3 R4 stored_len", stored_len, kept);
      chk("R4 overflow flag", overflow, (n > DEP));

      // R7: second fill request refused even with space left
      request(1'b0);
      chk("R7 refuse fill while parked", cmd_refuse, 1);
      chk("R7 length unchanged", stored_len, kept);
      chk("R7 still holding", has_data, 1);

      // R9: early release has no effect
      release_pulse();
      chk("R9 busy after early release", busy, 1);
      chk("R9 has_data after early release", has_data, 1);

      request(1'b1);
      chk("R5 grant replay", cmd_grant, 1);
      drain(kept, seed, gappy);

      chk("R8 has_data after delivery", has_data, 0);
      chk("R8 busy until release", busy, 1);
      tick();
      chk("R8 still busy without release", busy, 1);
      release_pulse();
      chk("R8 idle after release", busy, 0);
      chk("R8 length cleared", stored_len, 0);
      chk("R8 overflow cleared", overflow, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule